// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit RISC core, together with the core's status register. Each cycle the core presents an operation, two operands and a bit selector. The block computes the result and the next status value combinationally. The status register takes that next value on a clock edge when the execute strobe is high. The incoming carry, the old zero flag and the T flag are read from the block's own status register, so chained multi-byte arithmetic needs no extra wiring.

The operations are:
- add and subtract, each with and without carry;
- compare and compare-with-carry;
- AND, OR and XOR;
- one's and two's complement;
- increment and decrement;
- logical shifts and rotates through carry;
- arithmetic shift right and nibble swap;
- setting or clearing any single status flag;
- copying an operand bit into T, and writing T into a result bit.

Each operation writes only its own subset of the flags and leaves the others as they were.

Status bits, from bit 7 down to bit 0: I (interrupt enable), T (bit transfer), H (half carry), S (sign, N xor V), V (two's complement overflow), N (negative), Z (zero), C (carry/borrow). The operation codes are the `alu_op_e` enumeration in the package.

Top module: `alu8_status_unit`

## Requirements
- R1: After reset, and immediately while `rst_n` is low, `status_o` is 0x00. After the synchronized reset releases, `status_o` takes `flags_next_o` on a rising clock edge only when `exec_i` is 1; otherwise it holds.
- R2: For OP_ADD and OP_ADC, `res_o` is opa + opb (+ C for OP_ADC), modulo 256. C is the carry out of bit 7, H the carry out of bit 3, V the signed overflow, N bit 7 of the result and Z is set when the result is zero.
- R3: For OP_SUB and OP_CMP, the difference is opa − opb. C is the borrow into bit 7, H the borrow from bit 4, V the signed overflow, N bit 7 and Z the zero test of the difference. For the compares, `res_o` equals opa.
- R4: For OP_SBC and OP_CPC, the difference is opa − opb − C and the other flags follow R3. Z is 1 only if the difference is zero and Z was already 1, so Z can be cleared but never newly set.
- R5: For OP_AND, OP_OR and OP_XOR, the result is the bitwise function. Z and N follow the result, V is cleared, and C, H, T and I are unchanged.
- R6: OP_INC adds 1 and sets V only for result 0x80. OP_DEC subtracts 1 and sets V only for result 0x7F. Both update Z and N and leave C and H unchanged.
- R7: OP_COM gives 0xFF − opa with C = 1 and V = 0. OP_NEG gives 0x00 − opa, with C set when the result is nonzero, V set when the result is 0x80, and H set to result bit 3 OR opa bit 3.
- R8: OP_LSL shifts left and OP_LSR shifts right, each inserting a 0. The bit shifted out goes to C, Z and N follow the result, and V = N xor C.
- R9: OP_ROL and OP_ROR rotate through carry: the old C enters the vacated end, the bit shifted out becomes C, and V = N xor C.
- R10: OP_ASR keeps bit 7, shifts bits 7..1 into 6..0, moves bit 0 into C, and sets V = N xor C.
- R11: OP_SWAP exchanges the high and low nibbles and changes no flag.
- R12: OP_FSET sets and OP_FCLR clears the status bit numbered by `sel_i`, bit positions as listed above (I = 7 … C = 0). No other bit changes, and `res_o` equals opa.
- R13: OP_BST copies bit `sel_i` of opa into T and changes nothing else. OP_BLD returns opa with bit `sel_i` replaced by T and changes no flag.
- R14: Every operation that writes N or V also writes S = N xor V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| exec_i | input | 1 | Commit `flags_next_o` to the status register at the next edge |
| op_i | input | 5 | Operation code (`alu_op_e`) |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| sel_i | input | 3 | Bit index for flag set/clear, bit store and bit load |
| res_o | output | 8 | Combinational result |
| flags_next_o | output | 8 | Next status register value |
| status_o | output | 8 | Current status register |

## Verification
The main function is driven from a table of operand pairs chosen to sit on the carry, half-carry and overflow boundaries: 0x7F+1, 0x80−1, 0xFF+carry-in and 0−0−borrow. Each pair is applied with a prepared incoming status, so that a wrong borrow polarity, a missed carry-in or a swapped H/V source shows up as a distinct mismatch. Preloading unrelated flags (I, T, C, H) before logic, increment and swap operations shows whether they are preserved or overwritten. The chained zero case is exercised with Z both clear and set before a zero difference. This distinguishes a sticky Z from a plain zero test. Directed steps cover reset, a commit suppressed by a low execute strobe, and an asynchronous reset in mid-run.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  parameter int DW = 8;
  localparam int NW = DW / 2;
  localparam int SW = $clog2(DW);

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
    OP_AND, OP_OR, OP_XOR, OP_COM, OP_NEG, OP_INC, OP_DEC,
    OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP,
    OP_FSET, OP_FCLR, OP_BST, OP_BLD
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          carry_i,
  input  logic          z_prev_i,
  input  logic          z_chain_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o,
  output logic          z_o
);
  logic [DW-1:0] b_eff;
  logic          cin;
  logic          cout;
  logic          hcarry;
  logic [NW-1:0] low_sum;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    cin   = sub_i ? ~carry_i : carry_i;
    {cout, res_o}     = {1'b0, a_i} + {1'b0, b_eff} + (DW+1)'(cin);
    {hcarry, low_sum} = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + (NW+1)'(cin);
    c_o = sub_i ? ~cout : cout;
    h_o = sub_i ? ~hcarry : hcarry;
    v_o = (a_i[DW-1] == b_eff[DW-1]) && (res_o[DW-1] != a_i[DW-1]);
    z_o = (res_o == '0) && (z_chain_i ? z_prev_i : 1'b1);
  end
endmodule

// File: rtl/alu8_logic_shift.sv
module alu8_logic_shift
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [SW-1:0] sel_i,
  input  logic          carry_i,
  input  logic          t_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] bld_vec;

  for (genvar gi = 0; gi < DW; gi++) begin : g_bld
    assign bld_vec[gi] = (sel_i == SW'(gi)) ? t_i : a_i[gi];
  end

  always_comb begin
    res_o = a_i;
    c_o   = carry_i;
    v_o   = 1'b0;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  begin res_o = ~a_i; c_o = 1'b1; end
      OP_INC:  begin res_o = a_i + 1'b1; v_o = (res_o == MIN_NEG); end
      OP_DEC:  begin res_o = a_i - 1'b1; v_o = (res_o == MAX_POS); end
      OP_LSL:  begin res_o = {a_i[DW-2:0], 1'b0};      c_o = a_i[DW-1]; end
      OP_ROL:  begin res_o = {a_i[DW-2:0], carry_i};   c_o = a_i[DW-1]; end
      OP_LSR:  begin res_o = {1'b0, a_i[DW-1:1]};      c_o = a_i[0];    end
      OP_ROR:  begin res_o = {carry_i, a_i[DW-1:1]};   c_o = a_i[0];    end
      OP_ASR:  begin res_o = {a_i[DW-1], a_i[DW-1:1]}; c_o = a_i[0];    end
      OP_SWAP: res_o = {a_i[NW-1:0], a_i[DW-1:NW]};
      OP_BLD:  res_o = bld_vec;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_flag_update.sv
module alu8_flag_update
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] a_i,
  input  logic [7:0]    status_i,
  input  logic [DW-1:0] as_res_i,
  input  logic          as_c_i,
  input  logic          as_h_i,
  input  logic          as_v_i,
  input  logic          as_z_i,
  input  logic [DW-1:0] lg_res_i,
  input  logic          lg_c_i,
  input  logic          lg_v_i,
  output logic [DW-1:0] res_o,
  output logic [7:0]    flags_o
);
  always_comb begin
    flags_o = status_i;
    res_o   = a_i;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res_o         = as_res_i;
        flags_o[FL_C] = as_c_i;
        flags_o[FL_H] = as_h_i;
        flags_o[FL_V] = as_v_i;
        flags_o[FL_Z] = as_z_i;
        flags_o[FL_N] = as_res_i[DW-1];
        flags_o[FL_S] = as_res_i[DW-1] ^ as_v_i;
      end
      OP_CMP, OP_CPC: begin
        res_o         = a_i;
        flags_o[FL_C] = as_c_i;
        flags_o[FL_H] = as_h_i;
        flags_o[FL_V] = as_v_i;
        flags_o[FL_Z] = as_z_i;
        flags_o[FL_N] = as_res_i[DW-1];
        flags_o[FL_S] = as_res_i[DW-1] ^ as_v_i;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_COM: begin
        res_o         = lg_res_i;
        flags_o[FL_C] = lg_c_i;
        flags_o[FL_V] = lg_v_i;
        flags_o[FL_Z] = (lg_res_i == '0);
        flags_o[FL_N] = lg_res_i[DW-1];
        flags_o[FL_S] = lg_res_i[DW-1] ^ lg_v_i;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        res_o         = lg_res_i;
        flags_o[FL_C] = lg_c_i;
        flags_o[FL_Z] = (lg_res_i == '0);
        flags_o[FL_N] = lg_res_i[DW-1];
        flags_o[FL_V] = lg_res_i[DW-1] ^ lg_c_i;
        flags_o[FL_S] = lg_c_i;
      end
      OP_SWAP, OP_BLD: res_o = lg_res_i;
      OP_FSET: flags_o[sel_i] = 1'b1;
      OP_FCLR: flags_o[sel_i] = 1'b0;
      OP_BST:  flags_o[FL_T]  = a_i[sel_i];
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [SW-1:0] sel_i,
  output logic [DW-1:0] res_o,
  output logic [7:0]    flags_next_o,
  output logic [7:0]    status_o
);
  alu_op_e       op;
  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic [7:0]    status_q;
  logic          as_sub, as_carry, as_chain, is_neg;
  logic [DW-1:0] as_a, as_b, as_res, lg_res;
  logic          as_c, as_h, as_v, as_z, lg_c, lg_v;

  assign op = alu_op_e'(op_i);

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    is_neg   = (op == OP_NEG);
    as_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) ||
               (op == OP_CPC) || is_neg;
    as_carry = ((op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC)) && status_q[FL_C];
    as_chain = (op == OP_SBC) || (op == OP_CPC);
    as_a     = is_neg ? '0 : opa_i;
    as_b     = is_neg ? opa_i : opb_i;
  end

  alu8_addsub u_addsub (
    .a_i      (as_a),
    .b_i      (as_b),
    .sub_i    (as_sub),
    .carry_i  (as_carry),
    .z_prev_i (status_q[FL_Z]),
    .z_chain_i(as_chain),
    .res_o    (as_res),
    .c_o      (as_c),
    .h_o      (as_h),
    .v_o      (as_v),
    .z_o      (as_z)
  );

  alu8_logic_shift u_logic (
    .op_i   (op),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sel_i  (sel_i),
    .carry_i(status_q[FL_C]),
    .t_i    (status_q[FL_T]),
    .res_o  (lg_res),
    .c_o    (lg_c),
    .v_o    (lg_v)
  );

  alu8_flag_update u_flags (
    .op_i    (op),
    .sel_i   (sel_i),
    .a_i     (opa_i),
    .status_i(status_q),
    .as_res_i(as_res),
    .as_c_i  (as_c),
    .as_h_i  (as_h),
    .as_v_i  (as_v),
    .as_z_i  (as_z),
    .lg_res_i(lg_res),
    .lg_c_i  (lg_c),
    .lg_v_i  (lg_v),
    .res_o   (res_o),
    .flags_o (flags_next_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  status_q <= '0;
    else if (exec_i)  status_q <= flags_next_o;
  end

  assign status_o = status_q;
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          exec_i,
  input logic [4:0]    op_i,
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] res_o,
  input logic [7:0]    flags_next_o,
  input logic [7:0]    status_o
);
  logic is_arith;
  logic is_logic;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_ADC) || (op_i == OP_SUB) ||
                    (op_i == OP_SBC) || (op_i == OP_CMP) || (op_i == OP_CPC) ||
                    (op_i == OP_NEG);
  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(status_o)); // R1
  AST_EXEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> status_o == $past(flags_next_o)); // R1
  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP || op_i == OP_CPC) |-> res_o == opa_i); // R3
  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_SBC || op_i == OP_CPC) && !status_o[FL_Z]) |-> !flags_next_o[FL_Z]); // R4
  AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (!flags_next_o[FL_V] && flags_next_o[FL_C] == status_o[FL_C] &&
                  flags_next_o[FL_H] == status_o[FL_H])); // R5
  AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SWAP) |-> flags_next_o == status_o); // R11
  AST_BLD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BLD) |-> flags_next_o == status_o); // R13
  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    is_arith |-> flags_next_o[FL_S] == (flags_next_o[FL_N] ^ flags_next_o[FL_V])); // R14
endmodule

bind alu8_status_unit alu8_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .exec_i      (exec_i),
  .op_i        (op_i),
  .opa_i       (opa_i),
  .res_o       (res_o),
  .flags_next_o(flags_next_o),
  .status_o    (status_o)
);

// File: tb/alu8_status_unit_tb_top.sv
`timescale 1ns/1ps
module alu8_status_unit_tb_top;
  import alu8_pkg::*;

  localparam int CLK_NS = 20;

  typedef struct packed {
    alu_op_e    op;
    logic [7:0] a;
    logic [7:0] b;
    logic [2:0] sel;
    logic [7:0] fin;
    logic [7:0] res;
    logic [7:0] fl;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{OP_ADD,  8'h3A, 8'hC6, 3'd0, 8'h00, 8'h00, 8'h23},
    '{OP_ADD,  8'h7F, 8'h01, 3'd0, 8'hC0, 8'h80, 8'hEC},
    '{OP_ADC,  8'h10, 8'h20, 3'd0, 8'h01, 8'h31, 8'h00},
    '{OP_ADC,  8'hFF, 8'h00, 3'd0, 8'h01, 8'h00, 8'h23},
    '{OP_SUB,  8'h10, 8'h01, 3'd0, 8'h00, 8'h0F, 8'h20},
    '{OP_SUB,  8'h80, 8'h01, 3'd0, 8'h00, 8'h7F, 8'h38},
    '{OP_SUB,  8'h01, 8'h02, 3'd0, 8'h00, 8'hFF, 8'h35},
    '{OP_CMP,  8'h55, 8'h55, 3'd0, 8'h00, 8'h55, 8'h02},
    '{OP_CPC,  8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00},
    '{OP_SBC,  8'h00, 8'h00, 3'd0, 8'h02, 8'h00, 8'h02},
    '{OP_SBC,  8'h00, 8'h00, 3'd0, 8'h03, 8'hFF, 8'h35},
    '{OP_AND,  8'hF0, 8'h0F, 3'd0, 8'h29, 8'h00, 8'h23},
    '{OP_OR,   8'h80, 8'h01, 3'd0, 8'h00, 8'h81, 8'h14},
    '{OP_XOR,  8'hFF, 8'h0F, 3'd0, 8'hC1, 8'hF0, 8'hD5},
    '{OP_COM,  8'h00, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h15},
    '{OP_NEG,  8'h01, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h35},
    '{OP_NEG,  8'h80, 8'h00, 3'd0, 8'h00, 8'h80, 8'h0D},
    '{OP_NEG,  8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02},
    '{OP_INC,  8'h7F, 8'h00, 3'd0, 8'h21, 8'h80, 8'h2D},
    '{OP_INC,  8'hFF, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02},
    '{OP_DEC,  8'h80, 8'h00, 3'd0, 8'h00, 8'h7F, 8'h18},
    '{OP_DEC,  8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02},
    '{OP_LSL,  8'h81, 8'h00, 3'd0, 8'h00, 8'h02, 8'h19},
    '{OP_LSR,  8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 8'h1B},
    '{OP_ROL,  8'h40, 8'h00, 3'd0, 8'h01, 8'h81, 8'h0C},
    '{OP_ROR,  8'h02, 8'h00, 3'd0, 8'h01, 8'h81, 8'h0C},
    '{OP_ASR,  8'h81, 8'h00, 3'd0, 8'h00, 8'hC0, 8'h15},
    '{OP_SWAP, 8'h3C, 8'h00, 3'd0, 8'hA5, 8'hC3, 8'hA5},
    '{OP_BST,  8'h20, 8'h00, 3'd5, 8'h00, 8'h20, 8'h40},
    '{OP_BST,  8'hDF, 8'h00, 3'd5, 8'hFF, 8'hDF, 8'hBF},
    '{OP_BLD,  8'h00, 8'h00, 3'd7, 8'h40, 8'h80, 8'h40},
    '{OP_BLD,  8'hFF, 8'h00, 3'd0, 8'hBF, 8'hFE, 8'hBF},
    '{OP_FSET, 8'h5A, 8'h00, 3'd7, 8'h00, 8'h5A, 8'h80},
    '{OP_FCLR, 8'h5A, 8'h00, 3'd0, 8'hFF, 8'h5A, 8'hFE}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_i;
  logic [4:0] op_i;
  logic [7:0] opa_i, opb_i;
  logic [2:0] sel_i;
  logic [7:0] res_o, flags_next_o, status_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  alu8_status_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_i      (exec_i),
    .op_i        (op_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .sel_i       (sel_i),
    .res_o       (res_o),
    .flags_next_o(flags_next_o),
    .status_o    (status_o)
  );

  function automatic string req_of(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC:                  return "R2";
      OP_SUB, OP_CMP:                  return "R3";
      OP_SBC, OP_CPC:                  return "R4";
      OP_AND, OP_OR, OP_XOR:           return "R5";
      OP_INC, OP_DEC:                  return "R6";
      OP_COM, OP_NEG:                  return "R7";
      OP_LSL, OP_LSR:                  return "R8";
      OP_ROL, OP_ROR:                  return "R9";
      OP_ASR:                          return "R10";
      OP_SWAP:                         return "R11";
      OP_FSET, OP_FCLR:                return "R12";
      default:                         return "R13";
    endcase
  endfunction

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // preload the status register with FSET/FCLR one bit at a time (R12 path)
  task automatic set_flags(logic [7:0] val);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      op_i   = val[i] ? OP_FSET : OP_FCLR;
      sel_i  = 3'(i);
      opa_i  = 8'h00;
      exec_i = 1'b1;
    end
  endtask

  task automatic apply(vec_t v, int idx);
    set_flags(v.fin);
    @(negedge clk);
    op_i = v.op; opa_i = v.a; opb_i = v.b; sel_i = v.sel; exec_i = 1'b1;
    #2;
    check8(req_of(v.op), $sformatf("vec %0d result", idx), res_o, v.res);
    check8(req_of(v.op), $sformatf("vec %0d next flags (S per R14)", idx), flags_next_o, v.fl);
    @(posedge clk);
    #2;
    check8("R1", $sformatf("vec %0d committed status", idx), status_o, v.fl);
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_fails++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exec_i = 1'b0; op_i = OP_ADD;
    opa_i = 8'h00; opb_i = 8'h00; sel_i = 3'd0;
    repeat (3) @(posedge clk);
    #2;
    check8("R1", "status in reset", status_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check8("R1", "status after reset release", status_o, 8'h00);

    for (int i = 0; i < NV; i++) apply(VEC[i], i);

    // commit suppressed when exec_i is low
    set_flags(8'h5A);
    @(negedge clk);
    op_i = OP_ADD; opa_i = 8'hFF; opb_i = 8'h01; exec_i = 1'b0;
    #2;
    check8("R2", "idle add result", res_o, 8'h00);
    @(posedge clk);
    #2;
    check8("R1", "status held with exec low", status_o, 8'h5A);
    @(posedge clk);
    #2;
    check8("R1", "status still held", status_o, 8'h5A);

    // asynchronous reset in mid-run
    @(negedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check8("R1", "status on async reset", status_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check8("R1", "status after second release", status_o, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule